// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block is the receive side of a character-oriented asynchronous serial port. Each pulse on a receive-clock strobe advances a prescaler. One prescaler period, selected as 1, 16 or 64 pulses, gives one bit tick. At every tick the receive sequencer samples the serial line once.

A frame starts with a low start bit. It carries 7 or 8 data bits, least significant first, then an optional even or odd parity bit and one or two high stop bits. A complete frame goes to a single-entry holding register. A status byte reports the following:

- holding register full
- framing error
- parity error
- overrun
- carrier loss
- the clear-to-send input
- a pending interrupt

The active-low interrupt output requests service for receive-full, overrun or a captured carrier-loss edge.

A high carrier-loss input stops reception. Its rising edge discards any unread character and latches an interrupt. The latch is released only after the host reads the status byte and then the data register.

Top module: `async_rx_status`

## Requirements
- R1: While reset is held and just after it, rx_data is 0 and irq_n is 1. With carrier_lost low, status reads 0x02 with cts_in copied live into bit 3. The status layout is: bit0 full, bit1 constant 1, bit2 carrier flag, bit3 cts_in, bit4 framing error, bit5 overrun, bit6 parity error, bit7 interrupt pending.
- R2: The bit tick fires on every Nth rxc_pulse, where N is 1 for div_sel=0, 16 for div_sel=1, and 64 for div_sel=2 or 3. The line is sampled only on that tick.
- R3: While carrier_lost is high, or the carrier flag (status bit2) is still set, the receiver stays idle and stores no character.
- R4: A low line at a tick starts a frame. The data bits are taken least significant first, and a good frame loads rx_data and sets status bit0.
- R5: With char7=1, seven data bits are taken and rx_data bit 7 reads 0.
- R6: par_mode 1 is even parity, 2 is odd parity, and 0 or 3 means no parity bit. A parity bit that breaks the selected rule sets status bit6, and the character is still stored.
- R7: With two_stop=1 a second stop bit is required. If that bit is low, status bit4 is set and the character is not stored.
- R8: A low first stop bit sets status bit4 and the character is dropped. A good stop bit clears bit4.
- R9: If status bit0 is still set when the last data bit arrives, status bit5 is set and the new character is discarded. The held character is kept.
- R10: A data_rd strobe clears status bits 0, 5 and 6.
- R11: A rising edge of carrier_lost has these effects:
  - it sets status bit2;
  - it clears status bit0;
  - it latches an interrupt cause.
  The latch clears only on a data_rd that follows a stat_rd. Bit2 stays set while an interrupt is pending.
- R12: irq_n is low, and status bit7 is 1, exactly when irq_en is 1 and at least one of these is true: full, overrun, or the carrier latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rxc_pulse | input | 1 | One-cycle strobe per receive-clock period |
| rx_line | input | 1 | Serial data line, idle high |
| carrier_lost | input | 1 | High when the carrier is absent |
| cts_in | input | 1 | Clear-to-send level, reported in status bit 3 |
| div_sel | input | 2 | Prescaler select: 0 gives 1, 1 gives 16, 2 or 3 gives 64 |
| char7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| two_stop | input | 1 | 1 requires two stop bits |
| irq_en | input | 1 | Receive interrupt enable |
| stat_rd | input | 1 | Strobe marking a status read |
| data_rd | input | 1 | Strobe marking a data read |
| rx_data | output | DATA_W | Holding register |
| status | output | 8 | Line status byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with the default parameters: DATA_W of 8 and prescaler ratios of 16 and 64. With these defaults a 64-pulse bit period costs only about 1,400 clocks per frame, so all three divisor settings can be exercised, along with both character lengths. Most frames run at ratio 1, which leaves room to cover every parity mode, both stop-bit counts, overrun from back-to-back frames, and the full carrier-loss hold and release sequence. That sequence includes a data read that is not preceded by a status read and so must not release the latch.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_DATA  = 3'd1,
    RX_PAR   = 3'd2,
    RX_STOP1 = 3'd3,
    RX_STOP2 = 3'd4
  } rx_state_e;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  localparam int ST_FULL  = 0;
  localparam int ST_TXE   = 1;
  localparam int ST_CARR  = 2;
  localparam int ST_CTS   = 3;
  localparam int ST_FRAME = 4;
  localparam int ST_OVR   = 5;
  localparam int ST_PAR   = 6;
  localparam int ST_IRQ   = 7;

endpackage

// File: rtl/srx_bitclk.sv
module srx_bitclk #(
  parameter int RATIO_MID = 16,
  parameter int RATIO_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxc_pulse,
  input  logic [1:0] div_sel,
  output logic       bit_tick
);

  localparam int CW = $clog2(RATIO_HI);
  localparam logic [CW:0] M1_LO  = '0;
  localparam logic [CW:0] M1_MID = (CW+1)'(RATIO_MID - 1);
  localparam logic [CW:0] M1_HI  = (CW+1)'(RATIO_HI - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   last_cnt;
  logic          at_last;

  always_comb begin
    unique case (div_sel)
      2'd0:    last_cnt = M1_LO;
      2'd1:    last_cnt = M1_MID;
      default: last_cnt = M1_HI;
    endcase
  end

  assign at_last  = ({1'b0, cnt_q} >= last_cnt);
  assign bit_tick = rxc_pulse && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (rxc_pulse) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (rxc_pulse) cnt_q <= cnt_d;
  end

  // R2: the count restarts after a tick and only moves on a pulse
  a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (cnt_q == '0));
  a_r2_idle_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !rxc_pulse |=> $stable(cnt_q));

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              rx_line,
  input  logic              hold,
  input  logic              char7,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic              full,
  output logic              ev_load,
  output logic [DATA_W-1:0] ev_char,
  output logic              ev_ovr,
  output logic              ev_pe,
  output logic              ev_fe_set,
  output logic              ev_fe_clr
);

  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] LEN_LONG  = BW'(DATA_W);
  localparam logic [BW-1:0] LEN_SHORT = BW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              acc_q, acc_d;
  logic [BW-1:0]     left_q, left_d;
  logic              par_on, par_fold;

  assign par_on   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
  assign par_fold = acc_q ^ rx_line;
  assign ev_char  = char7 ? {1'b0, shift_q[DATA_W-1:1]} : shift_q;

  always_comb begin
    state_d   = state_q;
    shift_d   = shift_q;
    acc_d     = acc_q;
    left_d    = left_q;
    ev_load   = 1'b0;
    ev_ovr    = 1'b0;
    ev_pe     = 1'b0;
    ev_fe_set = 1'b0;
    ev_fe_clr = 1'b0;
    if (hold) begin
      state_d = RX_IDLE;
    end else if (bit_tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!rx_line) begin
            shift_d = '0;
            acc_d   = 1'b0;
            left_d  = char7 ? LEN_SHORT : LEN_LONG;
            state_d = RX_DATA;
          end
        end
        RX_DATA: begin
          shift_d = {rx_line, shift_q[DATA_W-1:1]};
          acc_d   = par_fold;
          left_d  = left_q - 1'b1;
          if (left_q == BW'(1)) begin
            ev_ovr  = full;
            state_d = par_on ? RX_PAR : RX_STOP1;
          end
        end
        RX_PAR: begin
          ev_pe   = (par_mode == PAR_EVEN) ? par_fold : !par_fold;
          state_d = RX_STOP1;
        end
        RX_STOP1: begin
          if (!rx_line) begin
            ev_fe_set = 1'b1;
            state_d   = RX_IDLE;
          end else if (two_stop) begin
            state_d   = RX_STOP2;
          end else begin
            ev_fe_clr = 1'b1;
            ev_load   = !full;
            state_d   = RX_IDLE;
          end
        end
        RX_STOP2: begin
          ev_fe_set = !rx_line;
          ev_fe_clr = rx_line;
          ev_load   = rx_line && !full;
          state_d   = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      shift_q <= '0;
      acc_q   <= 1'b0;
      left_q  <= '0;
    end else if (hold || bit_tick) begin
      state_q <= state_d;
      shift_q <= shift_d;
      acc_q   <= acc_d;
      left_q  <= left_d;
    end
  end

  // R3: a held receiver sits in idle on the next cycle
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (state_q == RX_IDLE));
  // R7: the second stop state is entered only from the first
  a_r7_stop2_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == RX_STOP2) |-> ($past(state_q) == RX_STOP1));

endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic [DATA_W-1:0] ev_char,
  input  logic              ev_ovr,
  input  logic              ev_pe,
  input  logic              ev_fe_set,
  input  logic              ev_fe_clr,
  input  logic              carrier_lost,
  input  logic              cts_in,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic [7:0]        status,
  output logic              irq_n,
  output logic              full,
  output logic              hold
);

  logic [DATA_W-1:0] data_q, data_d;
  logic full_q, full_d, ovr_q, ovr_d, pe_q, pe_d, fe_q, fe_d;
  logic carr_q, carr_d, latch_q, latch_d, armed_q, armed_d;
  logic carr_rise, irq_act;

  assign carr_rise = carrier_lost && !carr_q;
  assign irq_act   = irq_en && (full_q || ovr_q || latch_q);

  always_comb begin
    data_d  = ev_load ? ev_char : data_q;

    full_d  = full_q;
    if (carr_rise)    full_d = 1'b0;
    else if (ev_load) full_d = 1'b1;
    else if (data_rd) full_d = 1'b0;

    ovr_d = ev_ovr ? 1'b1 : (data_rd ? 1'b0 : ovr_q);
    pe_d  = ev_pe  ? 1'b1 : (data_rd ? 1'b0 : pe_q);

    fe_d = fe_q;
    if (ev_fe_set)      fe_d = 1'b1;
    else if (ev_fe_clr) fe_d = 1'b0;

    carr_d = carrier_lost ? 1'b1 : (irq_act ? carr_q : 1'b0);

    latch_d = latch_q;
    if (carr_rise)               latch_d = 1'b1;
    else if (data_rd && armed_q) latch_d = 1'b0;

    armed_d = armed_q;
    if (data_rd)                 armed_d = 1'b0;
    else if (stat_rd && latch_q) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      carr_q  <= 1'b0;
      latch_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ev_load) data_q <= data_d;
      full_q  <= full_d;
      ovr_q   <= ovr_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
      carr_q  <= carr_d;
      latch_q <= latch_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    status           = 8'h00;
    status[ST_FULL]  = full_q;
    status[ST_TXE]   = 1'b1;
    status[ST_CARR]  = carr_q;
    status[ST_CTS]   = cts_in;
    status[ST_FRAME] = fe_q;
    status[ST_OVR]   = ovr_q;
    status[ST_PAR]   = pe_q;
    status[ST_IRQ]   = irq_act;
  end

  assign rx_data = data_q;
  assign irq_n   = !irq_act;
  assign full    = full_q;
  assign hold    = carrier_lost || carr_q;

  // R9: overrun only rises over a held character, which is then kept
  a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(full_q));
  a_r9_data_kept_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(!full_q));
  // R10: a read with no new event leaves full and overrun clear
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !ev_load && !ev_ovr) |=> (!full_q && !ovr_q));
  // R11: carrier edge discards the held character; flag kept while pending
  a_r11_edge_drops_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> !full_q);
  a_r11_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (carr_q && !irq_n) |=> carr_q);

endmodule

// File: rtl/async_rx_status.sv
module async_rx_status #(
  parameter int DATA_W    = 8,
  parameter int RATIO_MID = 16,
  parameter int RATIO_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxc_pulse,
  input  logic              rx_line,
  input  logic              carrier_lost,
  input  logic              cts_in,
  input  logic [1:0]        div_sel,
  input  logic              char7,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic [7:0]        status,
  output logic              irq_n
);

  logic rst_meta, rst_core;
  logic bit_tick, full, hold;
  logic ev_load, ev_ovr, ev_pe, ev_fe_set, ev_fe_clr;
  logic [DATA_W-1:0] ev_char;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  srx_bitclk #(.RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI)) u_bitclk (
    .clk(clk), .rst_n(rst_core), .rxc_pulse(rxc_pulse),
    .div_sel(div_sel), .bit_tick(bit_tick)
  );

  srx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_core), .bit_tick(bit_tick), .rx_line(rx_line),
    .hold(hold), .char7(char7), .par_mode(par_mode), .two_stop(two_stop),
    .full(full), .ev_load(ev_load), .ev_char(ev_char), .ev_ovr(ev_ovr),
    .ev_pe(ev_pe), .ev_fe_set(ev_fe_set), .ev_fe_clr(ev_fe_clr)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_core), .ev_load(ev_load), .ev_char(ev_char),
    .ev_ovr(ev_ovr), .ev_pe(ev_pe), .ev_fe_set(ev_fe_set),
    .ev_fe_clr(ev_fe_clr), .carrier_lost(carrier_lost), .cts_in(cts_in),
    .irq_en(irq_en), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .status(status), .irq_n(irq_n),
    .full(full), .hold(hold)
  );

  // R12: the interrupt line never asserts with the enable low
  a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_core)
    !irq_n |-> irq_en);

endmodule

// File: tb/sim_async_rx_status.sv
module sim_async_rx_status;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, rxc_pulse, rx_line, carrier_lost, cts_in;
  logic [1:0] div_sel, par_mode;
  logic       char7, two_stop, irq_en, stat_rd, data_rd;
  logic [7:0] rx_data, status;
  logic       irq_n;

  async_rx_status u0 (
    .clk(clk), .rst_n(rst_n), .rxc_pulse(rxc_pulse), .rx_line(rx_line),
    .carrier_lost(carrier_lost), .cts_in(cts_in), .div_sel(div_sel),
    .char7(char7), .par_mode(par_mode), .two_stop(two_stop),
    .irq_en(irq_en), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .status(status), .irq_n(irq_n)
  );

  typedef struct {
    logic [7:0] d;
    logic [7:0] s;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  int   ratio  = 1;
  logic prev_full = 1'b0;
  logic mon_on = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every new character is matched against the queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (status[0] && !prev_full) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R3 unexpected character actual=%02h expected=none", rx_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.tag, " data"}, rx_data, e.d);
          chk({e.tag, " status"}, status, e.s);
        end
      end
      prev_full = status[0];
    end
  end

  task automatic pulse();
    rxc_pulse = 1'b1;
    @(negedge clk);
    rxc_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    rx_line = b;
    for (int k = 0; k < ratio; k++) pulse();
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic send(input logic [7:0] d, input logic flip_par, input int bad_stop);
    int   nb;
    logic p;
    nb = char7 ? 7 : 8;
    p  = 1'b0;
    put_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      put_bit(d[i]);
      p = p ^ d[i];
    end
    if (par_mode == 2'd1 || par_mode == 2'd2) begin
      if (par_mode == 2'd2) p = ~p;
      put_bit(p ^ flip_par);
    end
    put_bit(bad_stop == 1 ? 1'b0 : 1'b1);
    if (two_stop) put_bit(bad_stop == 2 ? 1'b0 : 1'b1);
    put_bit(1'b1);
  endtask

  task automatic expect_char(input logic [7:0] d, input logic pe, input string tag);
    exp_t e;
    e.d = d;
    e.s = {irq_en, pe, 1'b0, 1'b0, cts_in, 1'b0, 1'b1, 1'b1};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic strobe_read();
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; rxc_pulse = 1'b0; rx_line = 1'b1; carrier_lost = 1'b0;
    cts_in = 1'b1; div_sel = 2'd0; par_mode = 2'd0; char7 = 1'b0;
    two_stop = 1'b0; irq_en = 1'b1; stat_rd = 1'b0; data_rd = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset data", rx_data, 8'h00);
    chk("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 status after reset", status, 8'h0A);
    cts_in = 1'b0;
    #1;
    chk("R1 cts live", status, 8'h02);
    mon_on = 1'b1;

    // R4 8N1 at ratio 1
    expect_char(8'hA5, 1'b0, "R4 8N1");
    send(8'hA5, 1'b0, 0);
    chk("R12 irq low on full", {7'd0, irq_n}, 8'h00);
    strobe_read();
    chk("R10 read clears full", status, 8'h02);
    chk("R12 irq released", {7'd0, irq_n}, 8'h01);

    // R5 seven bits, even parity
    char7 = 1'b1; par_mode = 2'd1;
    expect_char(8'h5B, 1'b0, "R5 7E1");
    send(8'h5B, 1'b0, 0);
    chk("R5 bit7 zero", {7'd0, rx_data[7]}, 8'h00);
    strobe_read();
    expect_char(8'h7F, 1'b0, "R5 7E1 ones");
    send(8'h7F, 1'b0, 0);
    strobe_read();

    // R6 odd parity, good then bad
    char7 = 1'b0; par_mode = 2'd2;
    expect_char(8'hC3, 1'b0, "R6 8O1 good");
    send(8'hC3, 1'b0, 0);
    strobe_read();
    expect_char(8'h1E, 1'b1, "R6 8O1 bad parity");
    send(8'h1E, 1'b1, 0);
    strobe_read();
    chk("R10 read clears parity error", status, 8'h02);
    par_mode = 2'd1;
    expect_char(8'h01, 1'b1, "R6 8E1 bad parity");
    send(8'h01, 1'b1, 0);
    strobe_read();

    // R7 two stop bits
    two_stop = 1'b1;
    expect_char(8'h3C, 1'b0, "R7 8E2 good");
    send(8'h3C, 1'b0, 0);
    strobe_read();
    par_mode = 2'd0;
    send(8'h99, 1'b0, 2);
    chk("R7 bad second stop", status, 8'h12);
    expect_char(8'h42, 1'b0, "R8 good frame clears framing");
    send(8'h42, 1'b0, 0);
    strobe_read();
    two_stop = 1'b0;

    // R8 bad first stop
    send(8'h66, 1'b0, 1);
    chk("R8 framing error set", status, 8'h12);
    chk("R8 data not stored", rx_data, 8'h42);

    // R9 overrun
    expect_char(8'h11, 1'b0, "R9 first of pair");
    send(8'h11, 1'b0, 0);
    send(8'h22, 1'b0, 0);
    chk("R9 overrun status", status, 8'hA3);
    chk("R9 held char kept", rx_data, 8'h11);
    strobe_read();
    chk("R10 read clears overrun", status, 8'h02);

    // R12 with interrupts disabled
    irq_en = 1'b0;
    expect_char(8'h81, 1'b0, "R12 irq disabled");
    send(8'h81, 1'b0, 0);
    chk("R12 irq_n stays high", {7'd0, irq_n}, 8'h01);
    strobe_read();
    irq_en = 1'b1;

    // R2 ratios 16 and 64
    div_sel = 2'd1; ratio = 16;
    expect_char(8'h96, 1'b0, "R2 ratio 16");
    send(8'h96, 1'b0, 0);
    strobe_read();
    div_sel = 2'd2; ratio = 64;
    expect_char(8'h4D, 1'b0, "R2 ratio 64");
    send(8'h4D, 1'b0, 0);
    strobe_read();
    div_sel = 2'd0; ratio = 1;

    // R11 and R3 carrier loss
    expect_char(8'h77, 1'b0, "R11 char before carrier loss");
    send(8'h77, 1'b0, 0);
    carrier_lost = 1'b1;
    @(negedge clk);
    chk("R11 edge clears full, latches irq", status, 8'h86);
    send(8'h55, 1'b0, 0);
    chk("R3 no receive under carrier loss", status, 8'h86);
    carrier_lost = 1'b0;
    @(negedge clk);
    chk("R11 flag held while pending", status, 8'h86);
    send(8'h33, 1'b0, 0);
    chk("R3 held by latched flag", status, 8'h86);
    strobe_read();
    chk("R11 data read alone keeps latch", status, 8'h86);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    strobe_read();
    @(negedge clk);
    chk("R11 released after status then data", status, 8'h02);
    chk("R11 irq released", {7'd0, irq_n}, 8'h01);
    expect_char(8'h3A, 1'b0, "R3 receiver live again");
    send(8'h3A, 1'b0, 0);
    strobe_read();

    repeat (4) @(negedge clk);
    chk("R4 scoreboard drained", 8'(exp_q.size()), 8'h00);
    summary();
  end

endmodule